// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets a host reach the management registers of an external Ethernet PHY over a two-wire serial management bus. The host sees two registers. The command register holds a start/busy flag, a direction flag, a PHY address and a register address. The data register holds the write value, or the read result once the transaction ends. One write to the command register with its flag bit set starts a clause-22 frame on MDC/MDIO. The same bit reads back as 1 until the frame ends, so the host polls it to learn that the transaction is done.

MDC comes from the system clock through a divider parameter and runs only while a frame is being shifted. MDIO output changes only on falling MDC edges. During a read, the controller releases the output enable for the turnaround and data bits and samples the PHY's reply on rising MDC edges.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, both registers read 0, MDC is low and the MDIO output enable is low.
- R2: Command register layout: bit 0 is busy/start, bit 1 is write (1) or read (0), bits 8:4 are the register address and bits 16:12 are the PHY address. All other bits read 0. When idle, a command write with bit 0 set stores the fields and reads back with bit 0 = 1 on the next cycle.
- R3: Each transaction sends 64 bits in this order, each field MSB first: 32 ones, start 01, opcode (01 for write, 10 for read), PHY address, register address, turnaround (10 for a write), then 16 data bits.
- R4: MDC is low while idle. During a transaction its period is 2*HALF_DIV system clocks.
- R5: The MDIO output changes only in the cycle in which MDC falls, or when a frame is loaded while MDC is low.
- R6: During a read, the output enable is high for the first 46 bit times and low for the last 18. The PHY's 16 data bits are sampled on rising MDC edges, and the data register holds them once busy clears.
- R7: Busy stays set until the falling MDC edge that ends bit 64. It then clears, about 128*HALF_DIV clocks after the start.
- R8: A command register write while busy is set has no effect on the stored fields, and it does not start another frame.
- R9: A data register write while busy is set is ignored. After a write transaction, the data register still holds the value that was sent.
- R10: A command write with bit 0 clear while idle stores the fields without starting a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Host register access strobe |
| bus_we | input | 1 | Host write enable (1 = write) |
| bus_addr | input | 1 | Register select: 0 = command, 1 = data |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Output enable for mdio_o (1 = drive) |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
The stimulus mixes reads and writes at both ends of the address space (PHY and register addresses 0 and 31), at one-hot addresses, and with data words of all ones, all zeros and alternating patterns. This catches a swapped or shifted field in the captured frame, a wrong opcode or turnaround, and a bit-order error in the sampled read value. Each frame is checked bit by bit with the output-enable pattern and the MDC period. That separates a read from a write by more than the opcode, and shows whether the data phase is released one bit early or late. Directed cases start a frame while busy, write data while busy, and store a command without its start flag. These show that the busy bit guards every path into the registers.

// File: rtl/mdio_ctl_pkg.sv
package mdio_ctl_pkg;

    localparam int BUSY_BIT   = 0;
    localparam int WR_BIT     = 1;
    localparam int REG_LSB    = 4;
    localparam int PHY_LSB    = 12;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = 46;
    localparam int DATA_IDX   = 48;

    localparam logic SEL_CMD  = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
    } mdio_cmd_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c, logic [DATA_W-1:0] d);
        logic [1:0] op;
        logic [1:0] ta;
        op = c.wr ? 2'b01 : 2'b10;
        ta = c.wr ? 2'b10 : 2'b11;
        return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, ta, d};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } div_state_t;

    div_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        rise_tick = 1'b0;
        fall_tick = 1'b0;
        if (!en) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (s_q.cnt == CNT_LIM) begin
            s_d.cnt   = '0;
            s_d.mdc   = ~s_q.mdc;
            rise_tick = ~s_q.mdc;
            fall_tick = s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc = s_q.mdc;

    // R4
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  mdio_cmd_t         cmd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              active,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_word
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(TA_IDX);
    localparam logic [IDX_W-1:0] DAT_POS  = IDX_W'(DATA_IDX);

    typedef struct packed {
        logic                  active;
        logic                  wr;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sr;
        logic [DATA_W-1:0]     rd;
    } eng_state_t;

    eng_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!s_q.active) begin
            if (launch) begin
                s_d.active = 1'b1;
                s_d.wr     = cmd.wr;
                s_d.idx    = '0;
                s_d.sr     = build_frame(cmd, wr_data);
                s_d.rd     = '0;
            end
        end else begin
            if (rise_tick && !s_q.wr && (s_q.idx >= DAT_POS))
                s_d.rd = {s_q.rd[DATA_W-2:0], mdio_i};
            if (fall_tick) begin
                s_d.sr = {s_q.sr[FRAME_BITS-2:0], 1'b0};
                if (s_q.idx == LAST_IDX) begin
                    s_d.active = 1'b0;
                    done       = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active  = s_q.active;
    assign mdio_o  = s_q.sr[FRAME_BITS-1];
    assign mdio_oe = s_q.active & (s_q.wr | (s_q.idx < TA_POS));
    assign rd_word = s_q.rd;

    // R5
    mdio_hold_between_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !fall_tick) |=> $stable(mdio_o));

    // R6
    turnaround_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !s_q.wr && fall_tick && s_q.idx == TA_POS - IDX_W'(1)) |=> !mdio_oe);

    // R7
    frame_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!s_q.active && !mdio_oe));

endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
    import mdio_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_word,
    output logic              launch,
    output mdio_cmd_t         cmd,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy
);
    typedef struct packed {
        logic              busy;
        logic              launch;
        mdio_cmd_t         cmd;
        logic [DATA_W-1:0] data;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic cmd_hit, dat_hit;

    assign cmd_hit = bus_sel & bus_we & (bus_addr == SEL_CMD);
    assign dat_hit = bus_sel & bus_we & (bus_addr == SEL_DATA);

    always_comb begin
        s_d        = s_q;
        s_d.launch = 1'b0;
        if (done) begin
            s_d.busy = 1'b0;
            if (!s_q.cmd.wr) s_d.data = rd_word;
        end else if (!s_q.busy) begin
            if (cmd_hit) begin
                s_d.cmd.wr    = bus_wdata[WR_BIT];
                s_d.cmd.phy   = bus_wdata[PHY_LSB +: ADDR_W];
                s_d.cmd.regad = bus_wdata[REG_LSB +: ADDR_W];
                if (bus_wdata[BUSY_BIT]) begin
                    s_d.busy   = 1'b1;
                    s_d.launch = 1'b1;
                end
            end
            if (dat_hit) s_d.data = bus_wdata[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == SEL_CMD) begin
            bus_rdata[BUSY_BIT]               = s_q.busy;
            bus_rdata[WR_BIT]                 = s_q.cmd.wr;
            bus_rdata[REG_LSB +: ADDR_W]      = s_q.cmd.regad;
            bus_rdata[PHY_LSB +: ADDR_W]      = s_q.cmd.phy;
        end else begin
            bus_rdata[DATA_W-1:0]             = s_q.data;
        end
    end

    assign launch  = s_q.launch;
    assign cmd     = s_q.cmd;
    assign wr_data = s_q.data;
    assign busy    = s_q.busy;

    // R8
    cmd_hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && cmd_hit) |=> ($stable(s_q.cmd) && !s_q.launch));

    // R9
    data_hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && dat_hit && !done) |=> $stable(s_q.data));

    // R7
    busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !done) |=> s_q.busy);

    // R10
    no_start_without_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && cmd_hit && !bus_wdata[BUSY_BIT]) |=> (!s_q.busy && !s_q.launch));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_ctl_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic        bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              launch, busy, done, active, rise_tick, fall_tick;
    mdio_cmd_t         cmd;
    logic [DATA_W-1:0] wr_data, rd_word;

    mdio_reg_file u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done      (done),
        .rd_word   (rd_word),
        .launch    (launch),
        .cmd       (cmd),
        .wr_data   (wr_data),
        .busy      (busy)
    );

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (active),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .cmd       (cmd),
        .wr_data   (wr_data),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .active    (active),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rd_word   (rd_word)
    );

    // R2
    engine_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> busy);

endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
    localparam int HALF_DIV = 2;
    localparam int NVEC = 6;
    // entry: {wr, phy[4:0], reg[4:0], data[15:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b1, 5'h01, 5'h00, 16'hA5C3},
        {1'b0, 5'h1F, 5'h1F, 16'h8001},
        {1'b1, 5'h10, 5'h01, 16'hFFFF},
        {1'b0, 5'h00, 5'h10, 16'h0000},
        {1'b0, 5'h0A, 5'h15, 16'h3C5A},
        {1'b1, 5'h15, 5'h0A, 16'h0000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic mdc, mdio_o, mdio_oe;
    logic mdio_i = 1'b1;

    int checks = 0, errors = 0;
    int phy_cnt = 0, viol = 0;
    logic [15:0] phy_reply = '0;
    logic cap [64];
    logic oecap [64];
    realtime t_first, t_second;
    logic prev_o = 1'b0;

    always #2 clk = ~clk;

    mdio_mgmt_ctrl #(.HALF_DIV(HALF_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

    // PHY model: capture on rising MDC, reply after falling MDC
    initial forever begin
        @(posedge mdc);
        if (phy_cnt < 64) begin
            cap[phy_cnt]   = mdio_o;
            oecap[phy_cnt] = mdio_oe;
        end
        if (phy_cnt == 0) t_first = $realtime;
        if (phy_cnt == 1) t_second = $realtime;
        phy_cnt = phy_cnt + 1;
    end
    initial forever begin
        @(negedge mdc);
        if (phy_cnt >= 48 && phy_cnt < 64) mdio_i = phy_reply[63 - phy_cnt];
        else mdio_i = 1'b1;
    end
    initial forever begin
        @(negedge clk);
        if (mdio_o !== prev_o && mdc === 1'b1) viol = viol + 1;
        prev_o = mdio_o;
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] mkcmd(input logic wr, input logic [4:0] phy, input logic [4:0] rg, input logic go);
        return {15'b0, phy, 3'b0, rg, 2'b0, wr, go};
    endfunction

    function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, (wr ? 2'b10 : 2'b11), d};
    endfunction

    // polls busy; returns number of reads that saw busy set
    task automatic wait_idle(output int n);
        logic [31:0] r;
        n = 0;
        for (int k = 0; k < 5000; k++) begin
            bus_read(1'b0, r);
            if (!r[0]) break;
            n = n + 1;
        end
    endtask

    task automatic check_frame(input logic wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        logic [63:0] ef;
        int bad_bits, bad_oe;
        ef = exp_frame(wr, phy, rg, d);
        bad_bits = 0; bad_oe = 0;
        for (int k = 0; k < 64; k++) begin
            logic want_oe;
            want_oe = wr || (k < 46);
            if (want_oe && cap[k] !== ef[63-k]) bad_bits = bad_bits + 1;
            if (oecap[k] !== want_oe) bad_oe = bad_oe + 1;
        end
        check(bad_bits == 0, "R3 frame bits", 64'(bad_bits), 64'd0);
        check(bad_oe == 0, "R6 output enable pattern", 64'(bad_oe), 64'd0);
        check(phy_cnt == 64, "R3 frame length", 64'(phy_cnt), 64'd64);
        check((t_second - t_first) == 2.0 * HALF_DIV * 4.0, "R4 MDC period",
              64'($rtoi(t_second - t_first)), 64'(2 * HALF_DIV * 4));
    endtask

    initial begin : watchdog
        #600000;
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(1'b0, r); check(r == 32'h0, "R1 command after reset", 64'(r), 64'd0);
        bus_read(1'b1, r); check(r == 32'h0, "R1 data after reset", 64'(r), 64'd0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 MDC and OE low", {62'd0, mdc, mdio_oe}, 64'd0);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            logic wr; logic [4:0] phy, rg; logic [15:0] d;
            {wr, phy, rg, d} = VEC[v];
            phy_cnt = 0; viol = 0; phy_reply = d;
            if (wr) bus_write(1'b1, {16'h0, d});
            bus_write(1'b0, mkcmd(wr, phy, rg, 1'b1));
            bus_read(1'b0, r);
            check(r == mkcmd(wr, phy, rg, 1'b1), "R2 command readback while busy", 64'(r), 64'(mkcmd(wr, phy, rg, 1'b1)));
            wait_idle(n);
            n = n + 1;
            check(n >= 128 * HALF_DIV && n <= 128 * HALF_DIV + 3, "R7 busy duration", 64'(n), 64'(128 * HALF_DIV));
            check_frame(wr, phy, rg, d);
            check(viol == 0, "R5 MDIO change outside falling MDC", 64'(viol), 64'd0);
            bus_read(1'b1, r);
            check(r == {16'h0, d}, wr ? "R9 data kept after write" : "R6 read result", 64'(r), 64'(d));
            bus_read(1'b0, r);
            check(r == mkcmd(wr, phy, rg, 1'b0), "R7 busy clear at end", 64'(r), 64'(mkcmd(wr, phy, rg, 1'b0)));
            check(mdc == 1'b0, "R4 MDC low when idle", 64'(mdc), 64'd0);
        end

        // R10: store without start
        phy_cnt = 0;
        bus_write(1'b0, mkcmd(1'b1, 5'h03, 5'h07, 1'b0));
        repeat (40) @(negedge clk);
        bus_read(1'b0, r);
        check(r == mkcmd(1'b1, 5'h03, 5'h07, 1'b0), "R10 fields stored without start", 64'(r), 64'(mkcmd(1'b1, 5'h03, 5'h07, 1'b0)));
        check(phy_cnt == 0, "R10 no MDC activity", 64'(phy_cnt), 64'd0);

        // R8 / R9 on a read
        phy_cnt = 0; phy_reply = 16'h1234;
        bus_write(1'b0, mkcmd(1'b0, 5'h02, 5'h03, 1'b1));
        repeat (50) @(negedge clk);
        bus_write(1'b0, mkcmd(1'b1, 5'h1C, 5'h0E, 1'b1));
        bus_write(1'b1, 32'h0000_BEEF);
        bus_read(1'b0, r);
        check(r == mkcmd(1'b0, 5'h02, 5'h03, 1'b1), "R8 command ignored while busy", 64'(r), 64'(mkcmd(1'b0, 5'h02, 5'h03, 1'b1)));
        wait_idle(n);
        repeat (300) @(negedge clk);
        check(phy_cnt == 64, "R8 no second frame", 64'(phy_cnt), 64'd64);
        bus_read(1'b1, r);
        check(r == 32'h1234, "R9 data write ignored during read", 64'(r), 64'h1234);
        check_frame(1'b0, 5'h02, 5'h03, 16'h1234);

        // R9 on a write
        phy_cnt = 0;
        bus_write(1'b1, 32'h0000_0F0F);
        bus_write(1'b0, mkcmd(1'b1, 5'h04, 5'h05, 1'b1));
        repeat (30) @(negedge clk);
        bus_write(1'b1, 32'h0000_AAAA);
        wait_idle(n);
        bus_read(1'b1, r);
        check(r == 32'h0F0F, "R9 data write ignored during write", 64'(r), 64'h0F0F);
        check_frame(1'b1, 5'h04, 5'h05, 16'h0F0F);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule